// File: doc/BRIEF.md
# Autonegotiation Supervisor with Link Indicator

This block sits around the autonegotiation engine of an Ethernet PHY and decides when that engine may run. Negotiation is switched on either by a control-register bit or by an external strap pin. When it switches on, or when software writes the self-clearing restart bit, the block first holds a silent break-link window, then asks the engine to negotiate and waits for it to finish. The code-word exchange is outside this block and is reduced to a level request (`engineRun`) answered by a one-cycle `engineDone` pulse that carries the agreed speed and duplex.

During the silent window all transmission is suppressed, including link pulses. The link state is forced to fail for the whole window. After a successful exchange a status acknowledge flag rises and the negotiated speed and duplex are used. In every other case, including when negotiation is turned off, speed and duplex come from two control bits. The link state is reported both as a link-up status bit and as a separate link-fail bit. A set of active-low indicator outputs can each be configured to show it.

Top module: `autoneg_supervisor`

## Requirements
- R1: Negotiation is enabled when `cfgNegEnable` or `negEnablePin` is 1. One cycle after both are 0, `txQuiet`, `engineRun` and `negAck` are all 0.
- R2: When negotiation becomes enabled, `txQuiet` rises on the next clock edge. It stays high for exactly QUIET_MS × TICKS_PER_MS cycles. The default is 1350 ms, which lies inside the 1200–1500 ms window.
- R3: While `txQuiet` is 1, `linkUp` is 0 and `linkFail` is 1, whatever the value of `rxLinkDetect`.
- R4: In the cycle after the quiet window ends, `engineRun` goes to 1. It stays at 1 until `engineDone` is sampled high, and it then falls on that edge.
- R5: A `restartWrite` pulse while negotiation is enabled restarts a full-length quiet window from any state, including during the quiet window, during negotiation and after completion. A `restartWrite` pulse while negotiation is disabled has no effect on `txQuiet`.
- R6: `negAck` becomes 1 only on the edge where `engineDone` ends a run. It returns to 0 when a new quiet window starts or when negotiation is disabled.
- R7: While `negAck` is 0, `speed100` equals `cfgSpeed100` (1 = 100 Mbit/s) and `fullDuplex` equals `cfgFullDuplex` (1 = full duplex). While `negAck` is 1, these outputs hold the `engineSpeed100` and `engineFullDuplex` values that were sampled with `engineDone`.
- R8: Outside the quiet window, `linkUp` equals `rxLinkDetect` delayed by one cycle, and `linkFail` is its complement.
- R9: Indicator k is selected by `ledSel[2k+1:2k]`. Code 2'b01 means link: `ledN[k]` is 0 while `linkUp` is 1, and 1 otherwise. For every other code, `ledN[k]` is held at 1.
- R10: `restartBitRead` reads 1 in the cycle after a `restartWrite` pulse and 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgNegEnable | input | 1 | Control-register negotiation enable bit |
| negEnablePin | input | 1 | External negotiation enable pin |
| restartWrite | input | 1 | One-cycle write of 1 to the restart bit |
| cfgSpeed100 | input | 1 | Register speed select, 1 = 100 Mbit/s |
| cfgFullDuplex | input | 1 | Register duplex select, 1 = full |
| rxLinkDetect | input | 1 | Receive link detected |
| ledSel | input | 2*LED_COUNT | Per-indicator 2-bit select, code 01 = link |
| engineDone | input | 1 | Engine finished the exchange (pulse) |
| engineSpeed100 | input | 1 | Negotiated speed, valid with engineDone |
| engineFullDuplex | input | 1 | Negotiated duplex, valid with engineDone |
| engineRun | output | 1 | Request to the engine to negotiate |
| txQuiet | output | 1 | All transmission including link pulses suppressed |
| negAck | output | 1 | Negotiation completed status bit |
| restartBitRead | output | 1 | Read-back value of the restart bit |
| speed100 | output | 1 | Resolved speed |
| fullDuplex | output | 1 | Resolved duplex |
| linkUp | output | 1 | Link pass status bit |
| linkFail | output | 1 | Link fail status bit |
| ledN | output | LED_COUNT | Active-low indicator outputs |

## Verification
The hardest situations to reach are a restart that lands part-way through a window that is thousands of cycles long, and one that lands while the engine is still busy. The bench reaches them by counting cycles from the rising edge of `txQuiet`. It injects `restartWrite` at a chosen offset and then measures the remaining quiet length, which must be the full length again. To show the fallback, the negotiated results are chosen opposite to the register bits, so that every one of the four outcomes can be told apart from the register settings.

// File: rtl/autoneg_pkg.sv
package autoneg_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_QUIET = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } negState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic quietStart;     // begin a new break-link window
    logic holdLinkFail;   // window in progress
    logic latchResult;    // capture engine outcome
    logic clearAck;       // negotiation switched off
    logic useNegotiated;  // outputs follow captured outcome
  } ctlStrobe_t;

  localparam logic [1:0] LED_SEL_LINK = 2'b01;

endpackage

// File: rtl/autoneg_ctrl.sv
module autoneg_ctrl
  import autoneg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       negEnable,
  input  logic       restartReq,
  input  logic       quietDone,
  input  logic       engineDone,
  output ctlStrobe_t strobe,
  output negState_t  state
);

  negState_t nextState;
  logic      enPrev;
  logic      enRise;

  assign enRise = negEnable && !enPrev;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (!negEnable) begin
      nextState       = ST_OFF;
      strobe.clearAck = 1'b1;
    end else if (enRise || restartReq) begin
      nextState         = ST_QUIET;
      strobe.quietStart = 1'b1;
    end else begin
      case (state)
        ST_QUIET: if (quietDone) nextState = ST_RUN;
        ST_RUN: if (engineDone) begin
          nextState          = ST_DONE;
          strobe.latchResult = 1'b1;
        end
        default: ;
      endcase
    end
    strobe.holdLinkFail  = (state == ST_QUIET);
    strobe.useNegotiated = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_OFF;
      enPrev <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= negEnable;
    end
  end

  p_disable_goes_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !negEnable |=> state == ST_OFF);

  p_run_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && negEnable && !restartReq && !engineDone) |=> state == ST_RUN);

  p_restart_requeues_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (negEnable && restartReq) |=> state == ST_QUIET);

endmodule

// File: rtl/autoneg_datapath.sv
module autoneg_datapath
  import autoneg_pkg::*;
#(
  parameter int QUIET_CYC = 5400,
  parameter int LED_COUNT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctlStrobe_t             strobe,
  input  logic                   cfgSpeed100,
  input  logic                   cfgFullDuplex,
  input  logic                   engSpeed100,
  input  logic                   engFullDuplex,
  input  logic                   rxLinkDetect,
  input  logic                   restartWrite,
  input  logic [2*LED_COUNT-1:0] ledSel,
  output logic                   quietDone,
  output logic                   negAck,
  output logic                   speed100,
  output logic                   fullDuplex,
  output logic                   linkUp,
  output logic                   restartBitRead,
  output logic [LED_COUNT-1:0]   ledN
);

  localparam int CW = $clog2(QUIET_CYC + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(QUIET_CYC - 1);

  logic [CW-1:0] quietCnt;
  logic          ackQ;
  logic          negSpeedQ;
  logic          negDuplexQ;
  logic          linkPassQ;

  assign quietDone = strobe.holdLinkFail && (quietCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quietCnt       <= '0;
      ackQ           <= 1'b0;
      negSpeedQ      <= 1'b0;
      negDuplexQ     <= 1'b0;
      linkPassQ      <= 1'b0;
      restartBitRead <= 1'b0;
    end else begin
      restartBitRead <= restartWrite;
      if (strobe.quietStart)        quietCnt <= '0;
      else if (strobe.holdLinkFail) quietCnt <= quietCnt + 1'b1;

      if (strobe.quietStart || strobe.clearAck) ackQ <= 1'b0;
      else if (strobe.latchResult)              ackQ <= 1'b1;

      if (strobe.latchResult) begin
        negSpeedQ  <= engSpeed100;
        negDuplexQ <= engFullDuplex;
      end

      if (strobe.quietStart || (strobe.holdLinkFail && !quietDone)) linkPassQ <= 1'b0;
      else                                                          linkPassQ <= rxLinkDetect;
    end
  end

  assign negAck     = ackQ;
  assign linkUp     = linkPassQ;
  assign speed100   = strobe.useNegotiated ? negSpeedQ  : cfgSpeed100;
  assign fullDuplex = strobe.useNegotiated ? negDuplexQ : cfgFullDuplex;

  for (genvar g = 0; g < LED_COUNT; g++) begin : g_led
    logic [1:0] selCode;
    assign selCode = ledSel[2*g +: 2];
    assign ledN[g] = (selCode == LED_SEL_LINK) ? !linkPassQ : 1'b1;

    p_led_unselected_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (selCode != LED_SEL_LINK) |-> ledN[g]);
  end

  p_ack_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackQ) |-> $past(strobe.latchResult));

  p_restart_selfclear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restartBitRead && !restartWrite) |=> !restartBitRead);

  p_quiet_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdLinkFail |-> quietCnt <= LAST_CNT);

endmodule

// File: rtl/autoneg_supervisor.sv
module autoneg_supervisor
  import autoneg_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int QUIET_MS     = 1350,
  parameter int LED_COUNT    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfgNegEnable,
  input  logic                   negEnablePin,
  input  logic                   restartWrite,
  input  logic                   cfgSpeed100,
  input  logic                   cfgFullDuplex,
  input  logic                   rxLinkDetect,
  input  logic [2*LED_COUNT-1:0] ledSel,
  input  logic                   engineDone,
  input  logic                   engineSpeed100,
  input  logic                   engineFullDuplex,
  output logic                   engineRun,
  output logic                   txQuiet,
  output logic                   negAck,
  output logic                   restartBitRead,
  output logic                   speed100,
  output logic                   fullDuplex,
  output logic                   linkUp,
  output logic                   linkFail,
  output logic [LED_COUNT-1:0]   ledN
);

  localparam int QUIET_CYC = QUIET_MS * TICKS_PER_MS;

  ctlStrobe_t strobe;
  negState_t  state;
  logic       negEnable;
  logic       quietDone;

  assign negEnable = cfgNegEnable || negEnablePin;

  autoneg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .negEnable  (negEnable),
    .restartReq (restartWrite),
    .quietDone  (quietDone),
    .engineDone (engineDone),
    .strobe     (strobe),
    .state      (state)
  );

  autoneg_datapath #(.QUIET_CYC(QUIET_CYC), .LED_COUNT(LED_COUNT)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .cfgSpeed100    (cfgSpeed100),
    .cfgFullDuplex  (cfgFullDuplex),
    .engSpeed100    (engineSpeed100),
    .engFullDuplex  (engineFullDuplex),
    .rxLinkDetect   (rxLinkDetect),
    .restartWrite   (restartWrite),
    .ledSel         (ledSel),
    .quietDone      (quietDone),
    .negAck         (negAck),
    .speed100       (speed100),
    .fullDuplex     (fullDuplex),
    .linkUp         (linkUp),
    .restartBitRead (restartBitRead),
    .ledN           (ledN)
  );

  assign txQuiet   = (state == ST_QUIET);
  assign engineRun = (state == ST_RUN);
  assign linkFail  = !linkUp;

  p_quiet_forces_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txQuiet |-> (linkFail && !linkUp));

  p_run_after_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txQuiet) && negEnable && !$past(restartWrite) |-> engineRun);

  p_ack_with_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !negAck |-> (speed100 == cfgSpeed100 && fullDuplex == cfgFullDuplex));

endmodule

// File: tb/test_autoneg_supervisor.sv
module test_autoneg_supervisor;

  localparam int TPM  = 2;
  localparam int QMS  = 1350;
  localparam int QCYC = QMS * TPM;
  localparam int NLED = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgNegEnable = 0, negEnablePin = 0, restartWrite = 0;
  logic cfgSpeed100 = 0, cfgFullDuplex = 0, rxLinkDetect = 0;
  logic [2*NLED-1:0] ledSel = '0;
  logic engineDone = 0, engineSpeed100 = 0, engineFullDuplex = 0;
  logic engineRun, txQuiet, negAck, restartBitRead, speed100, fullDuplex, linkUp, linkFail;
  logic [NLED-1:0] ledN;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  autoneg_supervisor #(.TICKS_PER_MS(TPM), .QUIET_MS(QMS), .LED_COUNT(NLED)) i_autoneg_supervisor (
    .clk(clk), .rst_n(rst_n), .cfgNegEnable(cfgNegEnable), .negEnablePin(negEnablePin),
    .restartWrite(restartWrite), .cfgSpeed100(cfgSpeed100), .cfgFullDuplex(cfgFullDuplex),
    .rxLinkDetect(rxLinkDetect), .ledSel(ledSel), .engineDone(engineDone),
    .engineSpeed100(engineSpeed100), .engineFullDuplex(engineFullDuplex),
    .engineRun(engineRun), .txQuiet(txQuiet), .negAck(negAck), .restartBitRead(restartBitRead),
    .speed100(speed100), .fullDuplex(fullDuplex), .linkUp(linkUp), .linkFail(linkFail), .ledN(ledN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseRestart();
    restartWrite = 1;
    step();
    restartWrite = 0;
  endtask

  // counts the quiet cycles starting at the current sample
  task automatic measureQuiet(output int n);
    n = 0;
    while (txQuiet && n < QCYC + 10) begin
      if (!linkFail || linkUp) check(0, "R3 link forced fail in quiet", linkUp, 0);
      n++;
      step();
    end
  endtask

  task automatic finishRun(input bit sp, input bit dx);
    engineSpeed100 = sp; engineFullDuplex = dx; engineDone = 1;
    step();
    engineDone = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check(!txQuiet && !engineRun && !negAck && !restartBitRead, "R1 reset idle", {txQuiet, engineRun, negAck}, 0);
    check(linkFail && ledN == 2'b11, "R9 reset indicators", ledN, 3);

    // R7 fallback sweep while disabled
    for (int c = 0; c < 4; c++) begin
      cfgSpeed100 = c[0]; cfgFullDuplex = c[1];
      step();
      check(speed100 == c[0] && fullDuplex == c[1], "R7 disabled speed/duplex", {fullDuplex, speed100}, c);
    end

    // R8/R9 indicator sweep over link and every select pair
    for (int rx = 0; rx < 2; rx++) begin
      for (int s = 0; s < 16; s++) begin
        rxLinkDetect = rx[0]; ledSel = s[3:0];
        step();
        check(linkUp == rx[0] && linkFail == !rx[0], "R8 link follows detect", linkUp, rx);
        for (int k = 0; k < NLED; k++) begin
          bit expN;
          expN = (ledSel[2*k +: 2] == 2'b01) ? !rx[0] : 1'b1;
          check(ledN[k] == expN, "R9 indicator output", ledN[k], expN);
        end
      end
    end
    ledSel = 4'b0101;

    // R5/R10 restart while disabled
    pulseRestart();
    check(restartBitRead == 1, "R10 restart reads 1", restartBitRead, 1);
    check(!txQuiet, "R5 restart ignored when disabled", txQuiet, 0);
    step();
    check(restartBitRead == 0, "R10 restart self-clears", restartBitRead, 0);
    check(!txQuiet, "R5 still idle", txQuiet, 0);

    // R1/R2 enable through the pin
    cfgSpeed100 = 0; cfgFullDuplex = 0; rxLinkDetect = 1;
    negEnablePin = 1;
    step();
    check(txQuiet, "R1 pin enables", txQuiet, 1);
    check(ledN == 2'b11, "R3 indicators dark in quiet", ledN, 3);
    measureQuiet(n);
    check(n == QCYC, "R2 quiet length", n, QCYC);
    check(n >= 1200 * TPM && n <= 1500 * TPM, "R2 inside window", n, QCYC);
    check(engineRun && linkUp, "R4 run after quiet / R8 link back", {engineRun, linkUp}, 3);
    repeat (20) step();
    check(engineRun && !negAck, "R4 run held until done", {engineRun, negAck}, 2);
    check(speed100 == 0 && fullDuplex == 0, "R7 cfg before done", {fullDuplex, speed100}, 0);
    finishRun(1, 1);
    check(!engineRun && negAck, "R6 ack after done", {engineRun, negAck}, 1);
    check(speed100 && fullDuplex, "R7 negotiated result", {fullDuplex, speed100}, 3);

    // R1 disable clears everything
    negEnablePin = 0;
    step();
    check(!txQuiet && !engineRun && !negAck, "R1 disable idles / R6 ack clears", {txQuiet, engineRun, negAck}, 0);
    check(speed100 == 0 && fullDuplex == 0, "R7 back to cfg", {fullDuplex, speed100}, 0);

    // R7 sweep of negotiated results via register enable and restart
    cfgNegEnable = 1;
    step();
    for (int c = 0; c < 4; c++) begin
      cfgSpeed100 = !c[0]; cfgFullDuplex = !c[1];
      if (c != 0) begin
        pulseRestart();
        check(txQuiet && !negAck, "R5 restart after done / R6 ack clears", {txQuiet, negAck}, 2);
      end
      measureQuiet(n);
      check(n == QCYC - ((c == 0) ? 0 : 0), "R2 quiet length sweep", n, QCYC);
      finishRun(c[0], c[1]);
      check(negAck && speed100 == c[0] && fullDuplex == c[1], "R7 negotiated sweep", {fullDuplex, speed100}, c);
    end

    // R5 restart in the middle of the quiet window
    pulseRestart();
    repeat (1000) step();
    check(txQuiet, "R5 mid window", txQuiet, 1);
    pulseRestart();
    measureQuiet(n);
    check(n == QCYC, "R5 restart mid quiet full length", n, QCYC);

    // R5 restart during negotiation
    repeat (5) step();
    check(engineRun, "R4 engine busy", engineRun, 1);
    pulseRestart();
    check(txQuiet && !engineRun, "R5 restart during run", {txQuiet, engineRun}, 2);
    measureQuiet(n);
    check(n == QCYC, "R5 restart during run full length", n, QCYC);
    finishRun(1, 0);
    check(negAck && speed100 && !fullDuplex, "R6 ack after restarted run", {fullDuplex, speed100}, 1);

    cfgNegEnable = 0;
    step();
    check(!negAck, "R6 ack clears on disable", negAck, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule